// File: doc/BRIEF.md
# Network Controller Command Register

This block is the command register of an Ethernet-style controller. It is a single byte that a host writes over a plain register bus and reads back at any time. The byte chooses which of four register pages the host is looking at. It brings the controller online or takes it offline. It requests one frame transmission at a time. It also switches early-transmit address checking on or off. The frame datapath, the DMA engines and the address comparator sit outside the block. They see it only through the levels and the strobe it drives.

Three kinds of control live in the byte. The start and stop bits drive a persistent run state. Stop does not cut the link at once. It forbids new work, then waits until both the transmit side and the receive side report idle, and only then raises a reset-complete flag. The transmit-request bit issues a single-cycle go strobe and stays set until the transmit side reports completion or abort. The two check bits act as set and clear commands for a latched enable. That enable keeps its value after the bits are written back to zero.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: The read byte is laid out, from bit 7 down to bit 0, as page-high, page-low, reserved, check-on, check-off, transmit-request, start, stop. After reset it reads 0x01. Every stored bit except transmit-request takes the written value on each write.
- R2: `page_idx` is built as {bit 6, bit 7} of the stored byte. A byte with both page bits clear gives 0, bit 7 alone gives 1, bit 6 alone gives 2, and both bits give 3.
- R3: Bit 5 of the read byte is always 0, whatever value is written to it.
- R4: A write with bit 1 set and bit 0 clear sets `online` one cycle later and clears `rst_done`. A later write with bit 1 clear leaves `online` high.
- R5: A write with bit 0 set clears `online` one cycle later. Stop wins over a start written in the same byte.
- R6: After a stop write, `rst_done` reads 0. It becomes 1 one cycle after the first clock edge at which `tx_idle` and `rx_idle` are both high. It reads 1 out of reset.
- R7: Writing 1 to bit 2 while `online` is high and the request bit is clear sets the request bit, which reads back as 1. The same write is ignored while offline: the bit reads 0 and no strobe is issued.
- R8: The request bit is cleared one cycle after `tx_done` or `tx_abort`. That clear wins over a new request in the same cycle. Writing 0 to bit 2 does not clear the request bit.
- R9: Writing 1 to bit 4 sets `chk_en`. It stays set after bit 4 is written back to 0.
- R10: Writing 1 to bit 3 clears `chk_en`, which stays clear until bit 4 is written again. When bits 3 and 4 are written together, `chk_en` is cleared.
- R11: `tx_go` is a one-cycle pulse, high in the cycle in which an accepted request first reads back as set. It is never high while `online` is low, and a byte that carries both stop and transmit-request produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the command byte |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current command byte as seen by the host |
| tx_done | input | 1 | Transmit side finished the current frame |
| tx_abort | input | 1 | Transmit side gave up on the current frame |
| tx_idle | input | 1 | Transmit side has no outstanding work |
| rx_idle | input | 1 | Receive side has no outstanding work |
| page_idx | output | 2 | Selected register page, 0 to 3 |
| online | output | 1 | Controller may send and receive frames |
| tx_go | output | 1 | One-cycle strobe that starts a transmission |
| chk_en | output | 1 | Early-transmit address checking enabled |
| rst_done | output | 1 | Offline and all outstanding work drained |

## Verification
The bench goes after the priority corners:
- A byte holding both start and stop must leave the controller offline. A design with the wrong priority would come online.
- A byte holding both check bits must leave checking off.
- A completion arriving in the same cycle as a new request must leave the request bit clear.

The bench also writes the request bit while offline and in the same byte as stop. A design that got these wrong would emit a `tx_go` strobe with the link down. It holds the idle flags low after a stop to catch a design that reports reset-complete before the datapath has drained. It checks that the request bit survives a write of 0. Last, it walks all four page codes to expose a design that swapped the two page bits.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

   // Stored command byte, most significant field first.
   typedef struct packed {
      logic [1:0] page;     // [7] high, [6] low of the written pair
      logic       rsv;      // always zero
      logic       chk_on;   // one-shot: enable early-transmit checking
      logic       chk_off;  // one-shot: disable early-transmit checking
      logic       txreq;    // transmit request, cleared by hardware
      logic       start;    // bring online
      logic       stop;     // take offline after draining
   } cmd_byte_t;

   localparam cmd_byte_t CMD_RESET = '{page: 2'b00, rsv: 1'b0, chk_on: 1'b0,
                                       chk_off: 1'b0, txreq: 1'b0, start: 1'b0,
                                       stop: 1'b1};

   // Page index from the stored pair: bit 6 is the weight-2 bit.
   function automatic logic [1:0] page_of(input logic [1:0] pair);
      return {pair[0], pair[1]};
   endfunction

endpackage

// File: rtl/cmd_run_ctl.sv
module cmd_run_ctl #(
   parameter bit DONE_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   input  logic tx_idle,
   input  logic rx_idle,
   output logic online,
   output logic rst_done
);

   logic draining_q;
   logic online_q;
   logic done_q;
   logic both_idle;

   assign both_idle = tx_idle & rx_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         online_q   <= 1'b0;
         draining_q <= 1'b0;
         done_q     <= DONE_INIT;
      end else if (stop_req) begin
         online_q   <= 1'b0;
         draining_q <= 1'b1;
         done_q     <= 1'b0;
      end else if (start_req) begin
         online_q   <= 1'b1;
         draining_q <= 1'b0;
         done_q     <= 1'b0;
      end else if (draining_q && both_idle) begin
         draining_q <= 1'b0;
         done_q     <= 1'b1;
      end
   end

   assign online   = online_q;
   assign rst_done = done_q;

endmodule

// File: rtl/cmd_tx_req.sv
module cmd_tx_req #(
   parameter bit GO_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic stop_req,
   input  logic online,
   input  logic tx_done,
   input  logic tx_abort,
   output logic txreq,
   output logic tx_go
);

   logic req_q;
   logic finish;
   logic accept;

   assign finish = tx_done | tx_abort;
   assign accept = set_req & online & ~req_q & ~stop_req & ~finish;

   always_ff @(posedge clk) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (finish) req_q <= 1'b0;
      else if (accept) req_q <= 1'b1;
   end

   assign txreq = req_q;

   generate
      if (GO_REG) begin : g_go_reg
         logic go_q;
         always_ff @(posedge clk) begin
            if (!rst_n) go_q <= 1'b0;
            else        go_q <= accept;
         end
         assign tx_go = go_q;
      end else begin : g_go_comb
         assign tx_go = accept;
      end
   endgenerate

endmodule

// File: rtl/cmd_chk_latch.sv
module cmd_chk_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   output logic chk_en
);

   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (off_req) en_q <= 1'b0;
      else if (on_req)  en_q <= 1'b1;
   end

   assign chk_en = en_q;

endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
   import nic_cmd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 2,
   parameter bit GO_REG    = 1'b1,
   parameter bit DONE_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tx_done,
   input  logic              tx_abort,
   input  logic              tx_idle,
   input  logic              rx_idle,
   output logic [PAGE_W-1:0] page_idx,
   output logic              online,
   output logic              tx_go,
   output logic              chk_en,
   output logic              rst_done
);

   localparam int BYTE_W = $bits(cmd_byte_t);

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("nic_cmd_ctrl: DATA_W must equal the command byte width");
      end
      if (PAGE_W != 2) begin : g_bad_page
         $error("nic_cmd_ctrl: PAGE_W must be 2");
      end
   endgenerate

   cmd_byte_t wr_b;
   cmd_byte_t store_q;
   cmd_byte_t view;
   logic      txreq;
   logic      start_req;
   logic      stop_req;

   assign wr_b      = cmd_byte_t'(wr_data);
   assign stop_req  = wr_en & wr_b.stop;
   assign start_req = wr_en & wr_b.start & ~wr_b.stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= CMD_RESET;
      end else if (wr_en) begin
         store_q.page    <= wr_b.page;
         store_q.rsv     <= 1'b0;
         store_q.chk_on  <= wr_b.chk_on;
         store_q.chk_off <= wr_b.chk_off;
         store_q.txreq   <= 1'b0;
         store_q.start   <= wr_b.start;
         store_q.stop    <= wr_b.stop;
      end
   end

   cmd_run_ctl #(.DONE_INIT(DONE_INIT)) run_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .stop_req (stop_req),
      .tx_idle  (tx_idle),
      .rx_idle  (rx_idle),
      .online   (online),
      .rst_done (rst_done)
   );

   cmd_tx_req #(.GO_REG(GO_REG)) txr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (wr_en & wr_b.txreq),
      .stop_req(stop_req),
      .online  (online),
      .tx_done (tx_done),
      .tx_abort(tx_abort),
      .txreq   (txreq),
      .tx_go   (tx_go)
   );

   cmd_chk_latch chk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .on_req (wr_en & wr_b.chk_on),
      .off_req(wr_en & wr_b.chk_off),
      .chk_en (chk_en)
   );

   always_comb begin
      view       = store_q;
      view.rsv   = 1'b0;
      view.txreq = txreq;
   end

   assign rd_data  = DATA_W'(view);
   assign page_idx = page_of(store_q.page);

endmodule

// File: rtl/nic_cmd_ctrl_chk.sv
module nic_cmd_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       tx_done,
   input logic       tx_abort,
   input logic       tx_idle,
   input logic       rx_idle,
   input logic       online,
   input logic       tx_go,
   input logic       chk_en,
   input logic       rst_done
);

   a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5] == 1'b0);

   a_r5_stop_offline: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0]) |=> !online);

   a_r4_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!online && !(wr_en && wr_data[1] && !wr_data[0])) |=> !online);

   a_r6_done_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_done) |-> $past(tx_idle && rx_idle));

   a_r8_finish_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done || tx_abort) |=> !rd_data[2]);

   a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[3]) |=> !chk_en);

   a_r11_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |=> !tx_go);

   a_r11_go_online: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> online);

endmodule

bind nic_cmd_ctrl nic_cmd_ctrl_chk chk_bind_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .tx_done (tx_done),
   .tx_abort(tx_abort),
   .tx_idle (tx_idle),
   .rx_idle (rx_idle),
   .online  (online),
   .tx_go   (tx_go),
   .chk_en  (chk_en),
   .rst_done(rst_done)
);

// File: tb/nic_cmd_ctrl_tb_top.sv
module nic_cmd_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tx_done = 1'b0;
   logic       tx_abort = 1'b0;
   logic       tx_idle = 1'b1;
   logic       rx_idle = 1'b1;
   logic [7:0] rd_data;
   logic [1:0] page_idx;
   logic       online;
   logic       tx_go;
   logic       chk_en;
   logic       rst_done;

   int n_checks = 0;
   int n_errors = 0;

   // reference state
   logic [1:0] m_pg;
   logic       m_on_b, m_off_b, m_txp, m_sta, m_stp;
   logic       m_online, m_drain, m_done, m_chk, m_go;

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tx_done(tx_done), .tx_abort(tx_abort),
      .tx_idle(tx_idle), .rx_idle(rx_idle), .page_idx(page_idx),
      .online(online), .tx_go(tx_go), .chk_en(chk_en), .rst_done(rst_done)
   );

   function automatic logic [7:0] exp_rd();
      return {m_pg, 1'b0, m_on_b, m_off_b, m_txp, m_sta, m_stp};
   endfunction

   function automatic logic [1:0] exp_page();
      return {m_pg[0], m_pg[1]};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_pg = 2'b00; m_on_b = 0; m_off_b = 0; m_txp = 0; m_sta = 0; m_stp = 1;
      m_online = 0; m_drain = 0; m_done = 1; m_chk = 0; m_go = 0;
   endtask

   task automatic model_step(input logic w, input logic [7:0] d, input logic dn,
                             input logic ab, input logic ti, input logic ri);
      logic fin, acc;
      fin = dn | ab;
      acc = w & d[2] & m_online & ~m_txp & ~d[0] & ~fin;
      m_go = acc;
      if (fin) m_txp = 0; else if (acc) m_txp = 1;
      if (w && d[0]) begin m_drain = 1; m_done = 0; end
      else if (w && d[1]) begin m_drain = 0; m_done = 0; end
      else if (m_drain && ti && ri) begin m_drain = 0; m_done = 1; end
      if (w && d[0]) m_online = 0; else if (w && d[1]) m_online = 1;
      if (w && d[3]) m_chk = 0; else if (w && d[4]) m_chk = 1;
      if (w) begin
         m_pg = d[7:6]; m_on_b = d[4]; m_off_b = d[3]; m_sta = d[1]; m_stp = d[0];
      end
   endtask

   task automatic compare_all();
      check("R1 byte", rd_data, exp_rd());
      check("R2 page", {6'd0, page_idx}, {6'd0, exp_page()});
      check("R3 rsv", {7'd0, rd_data[5]}, 8'd0);
      check("R4/R5 online", {7'd0, online}, {7'd0, m_online});
      check("R6 rst_done", {7'd0, rst_done}, {7'd0, m_done});
      check("R7 txreq", {7'd0, rd_data[2]}, {7'd0, m_txp});
      check("R9 chk_en", {7'd0, chk_en}, {7'd0, m_chk});
      check("R11 tx_go", {7'd0, tx_go}, {7'd0, m_go});
   endtask

   task automatic cyc(input logic w, input logic [7:0] d, input logic dn = 1'b0,
                      input logic ab = 1'b0, input logic ti = 1'b1, input logic ri = 1'b1);
      @(negedge clk);
      wr_en = w; wr_data = d; tx_done = dn; tx_abort = ab; tx_idle = ti; rx_idle = ri;
      @(posedge clk);
      model_step(w, d, dn, ab, ti, ri);
      #1;
      compare_all();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2468));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset value
      check("R1 reset", rd_data, 8'h01);
      check("R6 reset done", {7'd0, rst_done}, 8'd1);
      check("R4 reset offline", {7'd0, online}, 8'd0);

      // R7 request while offline is ignored
      cyc(1, 8'h04);
      check("R7 offline ignored", {7'd0, rd_data[2]}, 8'd0);
      // R4 start, then clearing start keeps online
      cyc(1, 8'h02);
      check("R4 online", {7'd0, online}, 8'd1);
      cyc(1, 8'h00);
      check("R4 stays online", {7'd0, online}, 8'd1);
      // R2 page walk
      cyc(1, 8'h80); check("R2 page 80", {6'd0, page_idx}, 8'd1);
      cyc(1, 8'h40); check("R2 page 40", {6'd0, page_idx}, 8'd2);
      cyc(1, 8'hC0); check("R2 page C0", {6'd0, page_idx}, 8'd3);
      cyc(1, 8'h00); check("R2 page 00", {6'd0, page_idx}, 8'd0);
      // R7 / R11 request with reserved bit set
      cyc(1, 8'h24);
      check("R11 go", {7'd0, tx_go}, 8'd1);
      check("R3 rsv written", {7'd0, rd_data[5]}, 8'd0);
      cyc(0, 8'h00);
      check("R11 single pulse", {7'd0, tx_go}, 8'd0);
      cyc(1, 8'h00);
      check("R8 write0 keeps", {7'd0, rd_data[2]}, 8'd1);
      cyc(0, 8'h00, 1'b1);
      check("R8 done clears", {7'd0, rd_data[2]}, 8'd0);
      // R8 abort clears, clear wins over same-cycle request
      cyc(1, 8'h04);
      cyc(1, 8'h04, 1'b0, 1'b1);
      check("R8 abort clears", {7'd0, rd_data[2]}, 8'd0);
      cyc(1, 8'h04, 1'b1);
      check("R8 clear wins", {7'd0, rd_data[2]}, 8'd0);
      check("R8 no go", {7'd0, tx_go}, 8'd0);
      // R9 / R10 check latch
      cyc(1, 8'h10); check("R9 on", {7'd0, chk_en}, 8'd1);
      cyc(1, 8'h00); check("R9 persists", {7'd0, chk_en}, 8'd1);
      cyc(1, 8'h08); check("R10 off", {7'd0, chk_en}, 8'd0);
      cyc(1, 8'h00); check("R10 persists", {7'd0, chk_en}, 8'd0);
      cyc(1, 8'h10);
      cyc(1, 8'h18); check("R10 both", {7'd0, chk_en}, 8'd0);
      // R5 / R11 stop with request in same byte, R6 drain
      cyc(1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R5 offline", {7'd0, online}, 8'd0);
      check("R11 stop no go", {7'd0, tx_go}, 8'd0);
      cyc(0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
      cyc(0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R6 not yet", {7'd0, rst_done}, 8'd0);
      cyc(0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      check("R6 done", {7'd0, rst_done}, 8'd1);
      // R5 stop beats start
      cyc(1, 8'h03);
      check("R5 stop wins", {7'd0, online}, 8'd0);

      // random phase
      for (int i = 0; i < 2000; i++) begin
         logic w, dn, ab, ti, ri;
         logic [7:0] d;
         w  = ($urandom % 2) == 0;
         d  = 8'($urandom);
         dn = ($urandom % 8) == 0;
         ab = ($urandom % 16) == 0;
         ti = ($urandom % 4) != 0;
         ri = ($urandom % 4) != 0;
         cyc(w, d, dn, ab, ti, ri);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule